// File: doc/BRIEF.md
# Serial Time Slot Control Port

This block receives 8-bit serial commands and keeps the time slot assignments that a frame timing block uses to place its frame sync pulses. It holds one assignment register for each frame sync output: a transmit group and a receive group of `NUM_CH` outputs each. Every register holds a `SLOT_W`-bit slot number and an enable flag. The serial clock, chip select, data, channel select and mode lines are asynchronous to the fast system clock. All of them are synchronized, and their edges are detected in the system clock domain.

A command is shifted in while chip select is low. It takes effect when chip select rises, and only if exactly eight bits arrived. The two leading bits of the command pick an action. The channel lines and the mode pin decide which register or registers the action applies to. Each register write pulses an update strobe for one system clock cycle, so the timing logic can adopt the new value at its next slot boundary.

Top module: `slot_cmd_port`

## Requirements
- R1: A command is 8 bits sent most significant bit first: bit 7 is the first action bit A1, bit 6 is the second action bit A0, and bits 5..0 are the slot field S5..S0.
- R2: A bit is captured on each falling edge of `sclk` while `cs_n` is low. Edges of `sclk` while `cs_n` is high are ignored and do not count toward the next command.
- R3: Registers change only after `cs_n` rises. Once eight bits have been shifted in, the outputs stay unchanged for as long as `cs_n` remains low.
- R4: With `mode_sep`=1, `ch_sel[1:0]` picks channel c. Action 00 writes registers c and c+NUM_CH, 01 writes register c only, 10 writes register c+NUM_CH only, and 11 writes both with the enable cleared.
- R5: With `mode_sep`=0, `ch_sel[2:0]` picks register index 0..7 directly, where indexes 4..7 are the receive group. Action 11 writes that register with the enable cleared, and any other action writes it with the enable set from the slot field.
- R6: A write whose S5 is 1 clears the enable of every register it targets. Every written register loads the full 6-bit slot field, whatever its enable becomes.
- R7: While reset is held, and immediately after it, all enables are 0 and all slot fields are 0.
- R8: If `cs_n` rises after any number of falling `sclk` edges other than eight, no register changes and no strobe is raised.
- R9: Each accepted command raises `upd_stb` for exactly one cycle, on the bits of the written registers only. The new register value is visible in that same cycle.
- R10: Output index i in `asg_en`, `asg_slot[i*6 +: 6]` and `upd_stb` is transmit output i for i < NUM_CH and receive output i-NUM_CH otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial command clock, data captured on falling edges |
| cs_n | input | 1 | Active-low command framing select |
| sdi | input | 1 | Serial command data |
| ch_sel | input | 3 | Channel or output select |
| mode_sep | input | 1 | 1: paired transmit/receive channels, 0: eight individual outputs |
| asg_en | output | 8 | Enable flag of each assignment register |
| asg_slot | output | 48 | Slot field of each register, 6 bits per register |
| upd_stb | output | 8 | One-cycle write strobe for each register |

## Verification
The hardest cases to reach from the ports are the framing faults. Chip select can rise after seven or nine clocks, and serial clock edges can arrive while the port is deselected. Because all inputs pass through synchronizers, these edges must be spaced far enough apart to be seen in the system domain. The bench therefore drives the serial lines with a slow, task-generated waveform. It sends short and long words, and it toggles the serial clock with chip select high just before a valid word. It also holds chip select low after eight bits to show that nothing is written early. Beyond these cases, the bench sweeps every channel, action and mode combination with varied slot values, and checks all eight registers after each command.

// File: rtl/slot_cmd_pkg.sv
package slot_cmd_pkg;
   // Leading two command bits: action code
   typedef enum logic [1:0] {
      ACT_BOTH = 2'b00,
      ACT_TX   = 2'b01,
      ACT_RX   = 2'b10,
      ACT_OFF  = 2'b11
   } act_e;
endpackage

// File: rtl/slot_cmd_sync.sv
module slot_cmd_sync #(
   parameter int          W      = 1,
   parameter int          STAGES = 2,
   parameter logic [W-1:0] RST   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] pipe [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         $error("slot_cmd_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= RST;
            else if (s == 0) pipe[s] <= d;
            else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/slot_cmd_shift.sv
module slot_cmd_shift #(
   parameter int WORD_W = 8,
   parameter int SEL_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_sclk,
   input  logic              s_cs_n,
   input  logic              s_sdi,
   input  logic [SEL_W-1:0]  s_sel,
   input  logic              s_mode,
   output logic [WORD_W-1:0] word,
   output logic [SEL_W-1:0]  sel_q,
   output logic              mode_q,
   output logic              word_vld
);
   localparam int CNT_W = $clog2(WORD_W + 2);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

   logic             p_sclk, p_cs_n;
   logic [CNT_W-1:0] cnt;
   logic             sclk_fall, cs_rise;

   assign sclk_fall = p_sclk & ~s_sclk;
   assign cs_rise   = ~p_cs_n & s_cs_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_sclk   <= 1'b0;
         p_cs_n   <= 1'b1;
         cnt      <= '0;
         word     <= '0;
         sel_q    <= '0;
         mode_q   <= 1'b1;
         word_vld <= 1'b0;
      end else begin
         p_sclk   <= s_sclk;
         p_cs_n   <= s_cs_n;
         word_vld <= 1'b0;
         if (cs_rise) begin
            word_vld <= (cnt == CNT_FULL);
            sel_q    <= s_sel;
            mode_q   <= s_mode;
            cnt      <= '0;
         end else if (s_cs_n) begin
            cnt <= '0;
         end else if (sclk_fall) begin
            word <= {word[WORD_W-2:0], s_sdi};
            if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/slot_cmd_decode.sv
module slot_cmd_decode
   import slot_cmd_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int SLOT_W = 6
) (
   input  logic [SLOT_W+1:0]           word,
   input  logic [$clog2(NUM_CH):0]     sel,
   input  logic                        mode_sep,
   output logic [2*NUM_CH-1:0]         wr_mask,
   output logic                        wr_en,
   output logic [SLOT_W-1:0]           wr_slot
);
   localparam int CH_W = $clog2(NUM_CH);
   localparam int NOUT = 2 * NUM_CH;

   act_e                act;
   logic [NUM_CH-1:0]   ch_hot;
   logic [NOUT-1:0]     idx_hot;

   assign act     = act_e'(word[SLOT_W+1:SLOT_W]);
   assign wr_slot = word[SLOT_W-1:0];
   assign wr_en   = ~word[SLOT_W-1] & (act != ACT_OFF);
   assign ch_hot  = NUM_CH'(1) << sel[CH_W-1:0];
   assign idx_hot = NOUT'(1) << sel;

   always_comb begin
      if (mode_sep) begin
         unique case (act)
            ACT_TX:  wr_mask = {{NUM_CH{1'b0}}, ch_hot};
            ACT_RX:  wr_mask = {ch_hot, {NUM_CH{1'b0}}};
            default: wr_mask = {ch_hot, ch_hot};
         endcase
      end else begin
         wr_mask = idx_hot;
      end
   end
endmodule

// File: rtl/slot_cmd_port.sv
module slot_cmd_port
   import slot_cmd_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int SLOT_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          sclk,
   input  logic                          cs_n,
   input  logic                          sdi,
   input  logic [$clog2(NUM_CH):0]       ch_sel,
   input  logic                          mode_sep,
   output logic [2*NUM_CH-1:0]           asg_en,
   output logic [2*NUM_CH*SLOT_W-1:0]    asg_slot,
   output logic [2*NUM_CH-1:0]           upd_stb
);
   localparam int CH_W   = $clog2(NUM_CH);
   localparam int SEL_W  = CH_W + 1;
   localparam int NOUT   = 2 * NUM_CH;
   localparam int WORD_W = SLOT_W + 2;
   localparam int SYN_W  = SEL_W + 4;
   localparam logic [SYN_W-1:0] SYN_RST = {1'b0, 1'b0, 1'b1, {SEL_W{1'b0}}, 1'b1};

   generate
      if (NUM_CH < 2 || NUM_CH != (1 << CH_W)) begin : g_chk_ch
         $error("slot_cmd_port: NUM_CH must be a power of two >= 2");
      end
      if (SLOT_W < 2) begin : g_chk_slot
         $error("slot_cmd_port: SLOT_W must be at least 2");
      end
   endgenerate

   logic [SYN_W-1:0]  syn_q;
   logic              s_sdi, s_sclk, s_cs_n, s_mode;
   logic [SEL_W-1:0]  s_sel;

   slot_cmd_sync #(.W(SYN_W), .STAGES(SYNC_STAGES), .RST(SYN_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sdi, sclk, cs_n, ch_sel, mode_sep}),
      .q     (syn_q)
   );
   assign {s_sdi, s_sclk, s_cs_n, s_sel, s_mode} = syn_q;

   logic [WORD_W-1:0] word;
   logic [SEL_W-1:0]  sel_q;
   logic              mode_q, word_vld;

   slot_cmd_shift #(.WORD_W(WORD_W), .SEL_W(SEL_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .s_sclk   (s_sclk),
      .s_cs_n   (s_cs_n),
      .s_sdi    (s_sdi),
      .s_sel    (s_sel),
      .s_mode   (s_mode),
      .word     (word),
      .sel_q    (sel_q),
      .mode_q   (mode_q),
      .word_vld (word_vld)
   );

   logic [NOUT-1:0]   wr_mask;
   logic              wr_en;
   logic [SLOT_W-1:0] wr_slot;

   slot_cmd_decode #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) u_dec (
      .word     (word),
      .sel      (sel_q),
      .mode_sep (mode_q),
      .wr_mask  (wr_mask),
      .wr_en    (wr_en),
      .wr_slot  (wr_slot)
   );

   generate
      for (genvar i = 0; i < NOUT; i++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               asg_en[i]                      <= 1'b0;
               asg_slot[i*SLOT_W +: SLOT_W]   <= '0;
               upd_stb[i]                     <= 1'b0;
            end else begin
               upd_stb[i] <= word_vld & wr_mask[i];
               if (word_vld && wr_mask[i]) begin
                  asg_en[i]                    <= wr_en;
                  asg_slot[i*SLOT_W +: SLOT_W] <= wr_slot;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/slot_cmd_port_chk.sv
module slot_cmd_port_chk #(
   parameter int NUM_CH = 4,
   parameter int SLOT_W = 6
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       mode_sep,
   input logic [2*NUM_CH-1:0]        asg_en,
   input logic [2*NUM_CH*SLOT_W-1:0] asg_slot,
   input logic [2*NUM_CH-1:0]        upd_stb
);
   localparam int NOUT = 2 * NUM_CH;

   logic [3:0] mode_age;
   logic       mode_prev;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_age  <= '0;
         mode_prev <= 1'b1;
      end else begin
         mode_prev <= mode_sep;
         if (mode_sep != mode_prev) mode_age <= '0;
         else if (mode_age != 4'hF) mode_age <= mode_age + 1'b1;
      end
   end

   // R7: registers are cleared while reset is held
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r7_reset_clear: assert (asg_en == '0 && asg_slot == '0);
      end
   end

   // R9: a strobe lasts a single cycle
   a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_stb != '0) |=> (upd_stb == '0));

   // R4: at most a transmit/receive pair is written by one command
   a_r4_pair_limit: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(upd_stb) <= 2);

   // R4: a double write always hits the same channel in both groups
   a_r4_pair_match: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(upd_stb) == 2) |->
         (upd_stb[NUM_CH-1:0] == upd_stb[NOUT-1:NUM_CH]));

   // R5: individual mode writes one register at a time
   a_r5_single_target: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_sep && mode_age >= 4'd8) |-> $onehot0(upd_stb));

   generate
      for (genvar i = 0; i < NOUT; i++) begin : g_chg
         // R9: a register changes only in its strobe cycle
         a_r9_change_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
            !($stable(asg_en[i]) && $stable(asg_slot[i*SLOT_W +: SLOT_W])) |-> upd_stb[i]);
      end
   endgenerate
endmodule

bind slot_cmd_port slot_cmd_port_chk #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) u_chk (.*);

// File: tb/slot_cmd_port_test.sv
module slot_cmd_port_test;
   localparam int NOUT = 8;
   localparam int HALF = 6;  // system clocks per serial half period

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0;
   logic       cs_n = 1'b1;
   logic       sdi = 1'b0;
   logic [2:0] ch_sel = '0;
   logic       mode_sep = 1'b1;
   logic [7:0]  asg_en;
   logic [47:0] asg_slot;
   logic [7:0]  upd_stb;

   int checks = 0;
   int errors = 0;
   logic       exp_en [NOUT];
   logic [5:0] exp_slot [NOUT];
   logic [7:0] stb_or;
   int         stb_cycles;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   slot_cmd_port uut (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
      .ch_sel(ch_sel), .mode_sep(mode_sep),
      .asg_en(asg_en), .asg_slot(asg_slot), .upd_stb(upd_stb)
   );

   always @(posedge clk) begin
      if (upd_stb != '0) begin
         stb_or     <= stb_or | upd_stb;
         stb_cycles <= stb_cycles + 1;
      end
   end

   task automatic wait_clk(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_regs(input string req);
      for (int i = 0; i < NOUT; i++) begin
         chk(asg_en[i] == exp_en[i] && asg_slot[i*6 +: 6] == exp_slot[i], req,
             {asg_en[i], asg_slot[i*6 +: 6]}, {exp_en[i], exp_slot[i]});
      end
   endtask

   task automatic clear_stb();
      @(negedge clk);
      stb_or = '0;
      stb_cycles = 0;
   endtask

   // shift nbits of w (MSB first, then zeros) and optionally raise cs_n
   task automatic shift_bits(input logic [7:0] w, input int nbits, input bit raise);
      cs_n = 1'b0;
      wait_clk(HALF);
      for (int b = 0; b < nbits; b++) begin
         sclk = 1'b1;
         sdi  = (b < 8) ? w[7-b] : 1'b0;
         wait_clk(HALF);
         sclk = 1'b0;
         wait_clk(HALF);
      end
      if (raise) begin
         cs_n = 1'b1;
         wait_clk(12);
      end
   endtask

   // reference model from R4, R5, R6
   function automatic logic [7:0] model_mask(input bit m, input logic [2:0] ch, input logic [1:0] act);
      logic [7:0] r;
      if (m) begin
         case (act)
            2'b01:   r = 8'b1 << ch[1:0];
            2'b10:   r = 8'b1 << (ch[1:0] + 4);
            default: r = (8'b1 << ch[1:0]) | (8'b1 << (ch[1:0] + 4));
         endcase
      end else begin
         r = 8'b1 << ch;
      end
      return r;
   endfunction

   task automatic send_and_check(input bit m, input logic [2:0] ch, input logic [7:0] w, input string req);
      logic [7:0] msk;
      mode_sep = m;
      ch_sel   = ch;
      wait_clk(4);
      clear_stb();
      shift_bits(w, 8, 1'b1);
      msk = model_mask(m, ch, w[7:6]);
      for (int i = 0; i < NOUT; i++) begin
         if (msk[i]) begin
            exp_en[i]   = !w[5] && (w[7:6] != 2'b11);
            exp_slot[i] = w[5:0];
         end
      end
      check_regs(req);
      chk(stb_or == msk && stb_cycles == 1, "R9 strobe", {stb_cycles[7:0], stb_or}, {8'd1, msk});
   endtask

   initial begin
      for (int i = 0; i < NOUT; i++) begin
         exp_en[i] = 1'b0;
         exp_slot[i] = '0;
      end
      stb_or = '0;
      stb_cycles = 0;
      wait_clk(5);
      check_regs("R7 reset");
      rst_n = 1'b1;
      wait_clk(5);
      check_regs("R7 after reset");
      chk(stb_cycles == 0, "R7 no strobe", stb_cycles, 0);

      // R4 / R10 / R1 / R6: paired mode sweep over channels and actions
      for (int c = 0; c < 4; c++) begin
         for (int a = 0; a < 4; a++) begin
            logic [5:0] s;
            s = 6'((c * 13 + a * 7 + 3) % 32);
            send_and_check(1'b1, 3'(c), {2'(a), s}, "R4 paired");
         end
      end
      // R6: slot field with the top bit set disables
      send_and_check(1'b1, 3'd2, {2'b00, 6'b10_0101}, "R6 top bit");
      send_and_check(1'b1, 3'd2, {2'b00, 6'd31}, "R1 max slot");

      // R5 / R10: individual mode sweep
      for (int c = 0; c < 8; c++) begin
         for (int a = 0; a < 4; a++) begin
            logic [5:0] s;
            s = 6'((c * 5 + a * 11 + 1) % 64);
            send_and_check(1'b0, 3'(c), {2'(a), s}, "R5 individual");
         end
      end
      for (int c = 0; c < 8; c++) begin
         send_and_check(1'b0, 3'(c), {2'b10, 6'(c + 20)}, "R5 reassign");
      end

      // R8: wrong bit counts are discarded
      foreach (exp_en[i]) begin end
      for (int nb = 6; nb <= 10; nb++) begin
         if (nb != 8) begin
            mode_sep = 1'b0;
            ch_sel = 3'd1;
            wait_clk(4);
            clear_stb();
            shift_bits(8'b00_000011, nb, 1'b1);
            check_regs("R8 bad count");
            chk(stb_cycles == 0, "R8 no strobe", stb_cycles, 0);
         end
      end

      // R2: serial clock edges while deselected are ignored
      clear_stb();
      for (int k = 0; k < 5; k++) begin
         sclk = 1'b1; sdi = 1'b1; wait_clk(HALF);
         sclk = 1'b0; wait_clk(HALF);
      end
      check_regs("R2 deselected idle");
      chk(stb_cycles == 0, "R2 no strobe", stb_cycles, 0);
      send_and_check(1'b0, 3'd6, {2'b01, 6'd9}, "R2 word after idle clocks");

      // R3: nothing written while cs_n stays low after a full word
      mode_sep = 1'b1;
      ch_sel = 3'd3;
      wait_clk(4);
      clear_stb();
      shift_bits({2'b00, 6'd17}, 8, 1'b0);
      wait_clk(30);
      check_regs("R3 held low");
      chk(stb_cycles == 0, "R3 no strobe", stb_cycles, 0);
      cs_n = 1'b1;
      wait_clk(12);
      exp_en[3] = 1'b1; exp_slot[3] = 6'd17;
      exp_en[7] = 1'b1; exp_slot[7] = 6'd17;
      check_regs("R3 after rise");
      chk(stb_or == 8'h88 && stb_cycles == 1, "R9 pair strobe", {stb_cycles[7:0], stb_or}, {8'd1, 8'h88});

      done = 1'b1;
   end

   initial begin
      for (int k = 0; k < 150000; k++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=done");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule